// File: doc/BRIEF.md
# Integer Execute ALU with Barrel Shifter

This block is the integer execute stage of a 32-bit, three-operand load/store RISC core. Each cycle it receives an instruction word together with the values already read from the two source registers. The rs value is the first operand and the rt value is the second. It decodes the instruction as a register-register operation, selected by the function field, or as an immediate operation, selected by the major opcode. It then builds the second operand from the rt value or from the 16-bit immediate, widened with sign or zero extension according to the instruction class. The result of the selected operation is captured in the stage register.

The block implements addition, subtraction, AND, OR, XOR, NOR, logical and arithmetic shifts by a constant or variable amount, signed and unsigned set-less-than, and load-upper-immediate. Register-file access, branch evaluation, multiply/divide and overflow traps are handled elsewhere in the core. An encoding the block does not recognise produces a zero result with the illegal flag set, so that a trap unit further down can act on it.

Top module: `exu_alu_core`

## Requirements
- R1: Outputs are registered. `result_o` and `illegal_o` reflect the instruction that was presented at the previous rising clock edge. An active-low asynchronous reset clears both outputs to zero.
- R2: With opcode 000000, funct 100000 (ADD) and 100001 (ADDU) give rs+rt, while 100010 (SUB) and 100011 (SUBU) give rs-rt. All four wrap modulo 2^32 and raise no flag.
- R3: With opcode 000000, funct 100100 gives AND, 100101 gives OR, 100110 gives XOR and 100111 gives NOR of rs and rt. NOR of a value with itself yields its bitwise inverse.
- R4: Funct 101010 (SLT) compares rs with rt as signed numbers and funct 101011 (SLTU) compares them as unsigned numbers. The result is exactly 1 when rs is less than rt and exactly 0 otherwise.
- R5: Funct 000000 (SLL), 000010 (SRL) and 000011 (SRA) shift the rt value by the shamt field, instr[10:6]. An amount of 0 passes the value through unchanged.
- R6: Funct 000100 (SLLV), 000110 (SRLV) and 000111 (SRAV) shift the rt value by rs[4:0]. Bits 31:5 of rs have no effect.
- R7: Right shifts of the SRA/SRAV kind copy bit 31 of the shifted value into every vacated position. SLL, SRL, SLLV and SRLV fill vacated positions with zeros.
- R8: The opcodes 001000 (ADDI), 001001 (ADDIU) and 001010 (SLTI) use instr[15:0] sign-extended to 32 bits as the second operand. ADDI and ADDIU add it to rs, and SLTI compares rs with it as signed numbers.
- R9: The opcodes 001100 (ANDI), 001101 (ORI) and 001110 (XORI) use instr[15:0] zero-extended to 32 bits as the second operand.
- R10: Opcode 001111 (LUI) returns instr[15:0] in bits 31:16 and zeros in bits 15:0, independent of both register operands.
- R11: Any opcode or funct value not listed in R2 to R10 gives `result_o` = 0 with `illegal_o` = 1. Every listed encoding gives `illegal_o` = 0.
- R12: Immediate-form instructions ignore the rt value, and the rd field never changes the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word to execute |
| src_a_i | input | XLEN | Value read from the rs register |
| src_b_i | input | XLEN | Value read from the rt register |
| result_o | output | XLEN | Registered ALU result |
| illegal_o | output | 1 | Registered flag for an unsupported encoding |

## Verification
The bench builds the block with its default XLEN of 32, the width that the instruction encodings require. At this width the shift amount has five bits, so constant and variable shifts can be driven to both ends of their range (0 and 31), and the sign bit sits at bit 31 where arithmetic shifts and signed compares read it. The vector table sets operand patterns that separate signed from unsigned comparison, sign from zero extension, and the low five bits of rs from its upper bits. Directed steps then check the reset state and a reset that arrives in the middle of a run.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 16;

    // major opcodes
    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_ADDIU = 6'b001001;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_XORI  = 6'b001110;
    localparam logic [5:0] OPC_LUI   = 6'b001111;

    // function field codes for opcode 000000
    localparam logic [5:0] FN_SLL  = 6'b000000;
    localparam logic [5:0] FN_SRL  = 6'b000010;
    localparam logic [5:0] FN_SRA  = 6'b000011;
    localparam logic [5:0] FN_SLLV = 6'b000100;
    localparam logic [5:0] FN_SRLV = 6'b000110;
    localparam logic [5:0] FN_SRAV = 6'b000111;
    localparam logic [5:0] FN_ADD  = 6'b100000;
    localparam logic [5:0] FN_ADDU = 6'b100001;
    localparam logic [5:0] FN_SUB  = 6'b100010;
    localparam logic [5:0] FN_SUBU = 6'b100011;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_XOR  = 6'b100110;
    localparam logic [5:0] FN_NOR  = 6'b100111;
    localparam logic [5:0] FN_SLT  = 6'b101010;
    localparam logic [5:0] FN_SLTU = 6'b101011;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_NOR,
        ALU_SLT,
        ALU_SLTU,
        ALU_SHL,
        ALU_SHR,
        ALU_SAR,
        ALU_LUI,
        ALU_NONE
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    use_imm;      // second operand from immediate
        logic    imm_sext;     // sign-extend the immediate
        logic    amt_from_reg; // shift amount from rs
        logic    bad;          // unsupported encoding
    } alu_ctl_t;

endpackage

// File: rtl/exu_alu_decode.sv
module exu_alu_decode
    import alu_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output alu_ctl_t   ctl_o
);

    always_comb begin
        ctl_o.fn           = ALU_NONE;
        ctl_o.use_imm      = 1'b0;
        ctl_o.imm_sext     = 1'b0;
        ctl_o.amt_from_reg = 1'b0;
        ctl_o.bad          = 1'b0;

        unique case (opcode_i)
            OPC_RTYPE: begin
                unique case (funct_i)
                    FN_SLL:  ctl_o.fn = ALU_SHL;
                    FN_SRL:  ctl_o.fn = ALU_SHR;
                    FN_SRA:  ctl_o.fn = ALU_SAR;
                    FN_SLLV: begin ctl_o.fn = ALU_SHL; ctl_o.amt_from_reg = 1'b1; end
                    FN_SRLV: begin ctl_o.fn = ALU_SHR; ctl_o.amt_from_reg = 1'b1; end
                    FN_SRAV: begin ctl_o.fn = ALU_SAR; ctl_o.amt_from_reg = 1'b1; end
                    FN_ADD, FN_ADDU: ctl_o.fn = ALU_ADD;
                    FN_SUB, FN_SUBU: ctl_o.fn = ALU_SUB;
                    FN_AND:  ctl_o.fn = ALU_AND;
                    FN_OR:   ctl_o.fn = ALU_OR;
                    FN_XOR:  ctl_o.fn = ALU_XOR;
                    FN_NOR:  ctl_o.fn = ALU_NOR;
                    FN_SLT:  ctl_o.fn = ALU_SLT;
                    FN_SLTU: ctl_o.fn = ALU_SLTU;
                    default: ctl_o.bad = 1'b1;
                endcase
            end
            OPC_ADDI, OPC_ADDIU: begin
                ctl_o.fn       = ALU_ADD;
                ctl_o.use_imm  = 1'b1;
                ctl_o.imm_sext = 1'b1;
            end
            OPC_SLTI: begin
                ctl_o.fn       = ALU_SLT;
                ctl_o.use_imm  = 1'b1;
                ctl_o.imm_sext = 1'b1;
            end
            OPC_ANDI: begin ctl_o.fn = ALU_AND; ctl_o.use_imm = 1'b1; end
            OPC_ORI:  begin ctl_o.fn = ALU_OR;  ctl_o.use_imm = 1'b1; end
            OPC_XORI: begin ctl_o.fn = ALU_XOR; ctl_o.use_imm = 1'b1; end
            OPC_LUI:  begin ctl_o.fn = ALU_LUI; ctl_o.use_imm = 1'b1; end
            default:  ctl_o.bad = 1'b1;
        endcase

        if (ctl_o.bad) begin
            ctl_o.fn = ALU_NONE;
        end
    end

endmodule

// File: rtl/exu_alu_operand.sv
module exu_alu_operand
    import alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  reg_val_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             sext_i,
    output logic [XLEN-1:0]  opb_o
);

    localparam int EXT_W = XLEN - IMM_W;

    logic             fill_bit;
    logic [XLEN-1:0]  imm_wide;

    assign fill_bit = sext_i & imm_i[IMM_W-1];
    assign imm_wide = {{EXT_W{fill_bit}}, imm_i};
    assign opb_o    = use_imm_i ? imm_wide : reg_val_i;

endmodule

// File: rtl/exu_alu_shift.sv
module exu_alu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            right_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] res_o
);

    logic            fill_bit;
    logic [XLEN-1:0] stage [0:SHW];

    assign fill_bit = arith_i & right_i & val_i[XLEN-1];
    assign stage[0] = val_i;

    // log2 barrel: stage k moves by 2**k positions when amt bit k is set
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [XLEN-1:0] moved;
        always_comb begin
            if (right_i) begin
                moved = {{D{fill_bit}}, stage[k][XLEN-1:D]};
            end else begin
                moved = {stage[k][XLEN-1-D:0], {D{1'b0}}};
            end
        end
        assign stage[k+1] = amt_i[k] ? moved : stage[k];
    end

    assign res_o = stage[SHW];

endmodule

// File: rtl/exu_alu_addsub.sv
module exu_alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);

    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   wide;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
    assign sum_o = wide[XLEN-1:0];

    // valid while sub_i is set: borrow means a < b unsigned
    assign lt_u_o = ~wide[XLEN];
    assign lt_s_o = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : wide[XLEN-1];

endmodule

// File: rtl/exu_alu_core.sv
module exu_alu_core
    import alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    src_a_i,
    input  logic [XLEN-1:0]    src_b_i,
    output logic [XLEN-1:0]    result_o,
    output logic               illegal_o
);

    localparam int SHW   = $clog2(XLEN);
    localparam int LOW_W = XLEN - IMM_W;

    alu_ctl_t         ctl;
    logic [XLEN-1:0]  opb;
    logic [SHW-1:0]   shamt;
    logic [XLEN-1:0]  sum;
    logic             lt_s;
    logic             lt_u;
    logic             do_sub;
    logic [XLEN-1:0]  shifted;
    logic [XLEN-1:0]  res_d;
    logic             unused_fields;

    assign unused_fields = ^instr_i[25:11];

    exu_alu_decode i_decode (
        .opcode_i (instr_i[31:26]),
        .funct_i  (instr_i[5:0]),
        .ctl_o    (ctl)
    );

    exu_alu_operand #(.XLEN(XLEN)) i_operand (
        .reg_val_i (src_b_i),
        .imm_i     (instr_i[IMM_W-1:0]),
        .use_imm_i (ctl.use_imm),
        .sext_i    (ctl.imm_sext),
        .opb_o     (opb)
    );

    assign do_sub = (ctl.fn == ALU_SUB) || (ctl.fn == ALU_SLT) || (ctl.fn == ALU_SLTU);

    exu_alu_addsub #(.XLEN(XLEN)) i_addsub (
        .a_i    (src_a_i),
        .b_i    (opb),
        .sub_i  (do_sub),
        .sum_o  (sum),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    assign shamt = ctl.amt_from_reg ? src_a_i[SHW-1:0] : instr_i[6 +: SHW];

    exu_alu_shift #(.XLEN(XLEN), .SHW(SHW)) i_shift (
        .val_i   (src_b_i),
        .amt_i   (shamt),
        .right_i ((ctl.fn == ALU_SHR) || (ctl.fn == ALU_SAR)),
        .arith_i (ctl.fn == ALU_SAR),
        .res_o   (shifted)
    );

    always_comb begin
        unique case (ctl.fn)
            ALU_ADD,
            ALU_SUB:  res_d = sum;
            ALU_AND:  res_d = src_a_i & opb;
            ALU_OR:   res_d = src_a_i | opb;
            ALU_XOR:  res_d = src_a_i ^ opb;
            ALU_NOR:  res_d = ~(src_a_i | opb);
            ALU_SLT:  res_d = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU: res_d = {{(XLEN-1){1'b0}}, lt_u};
            ALU_SHL,
            ALU_SHR,
            ALU_SAR:  res_d = shifted;
            ALU_LUI:  res_d = {instr_i[IMM_W-1:0], {LOW_W{1'b0}}};
            default:  res_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= res_d;
            illegal_o <= ctl.bad;
        end
    end

endmodule

// File: rtl/exu_alu_core_chk.sv
module exu_alu_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     instr_i,
    input logic            b_msb_i,
    input logic [XLEN-1:0] result_o,
    input logic            illegal_o
);

    logic armed;
    logic unused_chk;

    assign unused_chk = ^instr_i[25:16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R11: a flagged encoding never leaks a value
    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));

    // R11: a listed immediate opcode never raises the flag
    a_r11_addi_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && instr_i[31:26] == 6'b001000) |=> !illegal_o);

    // R4: set-less-than yields only 0 or 1
    a_r4_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && instr_i[31:26] == 6'b000000 && instr_i[5:1] == 5'b10101)
        |=> (result_o[XLEN-1:1] == '0));

    // R10: upper immediate lands in the top half, low half zero
    a_r10_lui_place: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && instr_i[31:26] == 6'b001111)
        |=> (result_o[XLEN-17:0] == '0 && result_o[XLEN-1:XLEN-16] == $past(instr_i[15:0])));

    // R7: arithmetic right shift of a negative value stays negative
    a_r7_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && instr_i[31:26] == 6'b000000 && instr_i[5:0] == 6'b000011 && b_msb_i)
        |=> result_o[XLEN-1]);

endmodule

bind exu_alu_core exu_alu_core_chk #(.XLEN(XLEN)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .b_msb_i   (src_b_i[XLEN-1]),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/test_exu_alu_core.sv
`timescale 1ns/1ps
module test_exu_alu_core;

    localparam int XLEN = 32;
    localparam int NV   = 31;

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] mk_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [4:0] sh,
                                         input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    localparam vec_t VECS [NV] = '{
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100000), 32'h7,        32'h5,        32'hC,        1'b0, 8'd2},  // R2 add
        '{mk_r(5'd1, 5'd2, 5'd9, 5'd0, 6'b100001), 32'hFFFFFFFF, 32'h2,        32'h1,        1'b0, 8'd2},  // R2 wrap
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100010), 32'h3,        32'h5,        32'hFFFFFFFE, 1'b0, 8'd2},  // R2 rs-rt
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100011), 32'hA,        32'h3,        32'h7,        1'b0, 8'd2},  // R2 subu
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100100), 32'hF0,       32'h3C,       32'h30,       1'b0, 8'd3},  // R3 and
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100101), 32'hF0,       32'h3C,       32'hFC,       1'b0, 8'd3},  // R3 or
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100110), 32'hF0,       32'h3C,       32'hCC,       1'b0, 8'd3},  // R3 xor
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100111), 32'hF0,       32'h3C,       32'hFFFFFF03, 1'b0, 8'd3},  // R3 nor
        '{mk_r(5'd1, 5'd1, 5'd3, 5'd0, 6'b100111), 32'hF0,       32'hF0,       32'hFFFFFF0F, 1'b0, 8'd3},  // R3 not
        '{mk_r(5'd1, 5'd2, 5'd4, 5'd0, 6'b101010), 32'hFFFFFFFF, 32'h0,        32'h1,        1'b0, 8'd4},  // R4 signed
        '{mk_r(5'd1, 5'd2, 5'd4, 5'd0, 6'b101011), 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 8'd4},  // R4 unsigned
        '{mk_r(5'd3, 5'd3, 5'd4, 5'd0, 6'b101010), 32'hFF,       32'hFF,       32'h0,        1'b0, 8'd4},  // R4 equal
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd3, 6'b000000), 32'h0,        32'hC,        32'h60,       1'b0, 8'd5},  // R5 sll 3
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd2, 6'b000010), 32'h0,        32'hC,        32'h3,        1'b0, 8'd5},  // R5 srl 2
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd0, 6'b000000), 32'h0,        32'hABCD,     32'hABCD,     1'b0, 8'd5},  // R5 amount 0
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd31, 6'b000010),32'h0,        32'h80000000, 32'h1,        1'b0, 8'd5},  // R5 amount 31
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd2, 6'b000011), 32'h0,        32'hFFFFFFFC, 32'hFFFFFFFF, 1'b0, 8'd7},  // R7 sra neg
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd4, 6'b000011), 32'h0,        32'h80000000, 32'hF8000000, 1'b0, 8'd7},  // R7 sign fill
        '{mk_r(5'd0, 5'd2, 5'd3, 5'd4, 6'b000010), 32'h0,        32'h80000000, 32'h08000000, 1'b0, 8'd7},  // R7 srl zero fill
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b000100), 32'h24,       32'h1,        32'h10,       1'b0, 8'd6},  // R6 sllv
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b000110), 32'hFFFFFFE1, 32'h80000000, 32'h40000000, 1'b0, 8'd6},  // R6 upper rs ignored
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd9, 6'b000111), 32'h1F,       32'h80000000, 32'hFFFFFFFF, 1'b0, 8'd6},  // R6 srav 31, shamt unused
        '{mk_i(6'b001000, 5'd1, 5'd2, 16'hFFFF),   32'h5,        32'h1234,     32'h4,        1'b0, 8'd8},  // R8 addi -1, R12 rt ignored
        '{mk_i(6'b001001, 5'd1, 5'd2, 16'h8000),   32'h0,        32'h0,        32'hFFFF8000, 1'b0, 8'd8},  // R8 addiu sext
        '{mk_i(6'b001010, 5'd1, 5'd2, 16'hFFFF),   32'hFFFFFFF0, 32'h0,        32'h1,        1'b0, 8'd8},  // R8 slti
        '{mk_i(6'b001101, 5'd1, 5'd2, 16'hFFFC),   32'h0,        32'hFFFFFFFF, 32'h0000FFFC, 1'b0, 8'd9},  // R9 ori zext
        '{mk_i(6'b001100, 5'd1, 5'd2, 16'h8001),   32'hFFFFFFFF, 32'h0,        32'h00008001, 1'b0, 8'd9},  // R9 andi
        '{mk_i(6'b001110, 5'd1, 5'd2, 16'hFFFF),   32'hFFFF0000, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd9},  // R9 xori
        '{mk_i(6'b001111, 5'd1, 5'd2, 16'h1234),   32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12340000, 1'b0, 8'd10}, // R10 lui
        '{mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b001000), 32'h7,        32'h5,        32'h0,        1'b1, 8'd11}, // R11 bad funct
        '{mk_i(6'b001011, 5'd1, 5'd2, 16'h0001),   32'h0,        32'h5,        32'h0,        1'b1, 8'd11}  // R11 bad opcode
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exu_alu_core #(.XLEN(XLEN)) i_exu_alu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .src_a_i   (src_a),
        .src_b_i   (src_b),
        .result_o  (result),
        .illegal_o (illegal)
    );

    task automatic check(input string req, input logic [31:0] exp_r, input logic exp_i);
        checks++;
        if (result !== exp_r || illegal !== exp_i) begin
            errors++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     req, result, illegal, exp_r, exp_i);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset state
        instr = mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100000);
        src_a = 32'h11;
        src_b = 32'h22;
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            @(negedge clk);
            instr = VECS[i].ins;
            src_a = VECS[i].a;
            src_b = VECS[i].b;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp, VECS[i].ill);
        end

        // R12: rd field changes nothing
        instr = mk_r(5'd1, 5'd2, 5'd31, 5'd0, 6'b100000);
        src_a = 32'h100;
        src_b = 32'h23;
        @(negedge clk);
        check("R12 rd field", 32'h123, 1'b0);

        // R1: one-cycle latency, output follows the previous edge only
        instr = mk_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b100010);
        src_a = 32'h50;
        src_b = 32'h10;
        #1;
        check("R1 holds until edge", 32'h123, 1'b0);
        @(negedge clk);
        check("R1 after edge", 32'h40, 1'b0);

        // R11 then legal: the flag clears
        instr = 32'hFC000000;
        @(negedge clk);
        check("R11 flag set", 32'h0, 1'b1);
        instr = mk_i(6'b001101, 5'd1, 5'd2, 16'h00F0);
        src_a = 32'h0F;
        @(negedge clk);
        check("R11 flag clears", 32'hFF, 1'b0);

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 32'hFF, 1'b0);

        finish_run();
    end

endmodule